// File: doc/BRIEF.md
# Isochronous OUT Ping-Pong Receive Buffer

This block holds isochronous OUT payload arriving from the bus in two equal banks, each as large as the configured isochronous packet. At any time one bank is the background bank, filled by the bus side during the current 1 ms frame. The other is the foreground bank, drained by the local processor. A start-of-frame strobe swaps the two roles. Bytes received in a frame therefore become readable only after the next frame boundary. The bus side sends no handshake and raises no completion interrupt. The only notice the processor gets is a one-cycle start-of-frame interrupt pulse.

The bus side presents already-decoded traffic. Each received byte comes as a strobe with its data. A packet ends with an end strobe that carries a good or bad flag, so CRC checking and token decoding live upstream. The processor side has a bit that selects the foreground bank, a show-ahead data port that steps forward on each read, a total byte count, an empty flag and a sticky overrun flag. Clearing the selection releases the foreground bank.

Top module: `iso_pingpong_rx`

## Requirements
- R1: After synchronous reset, cpu_empty_o is 1, cpu_count_o is 0, cpu_sel_o is 0, overrun_o is 0, sof_irq_o is 0 and cpu_data_o is 0.
- R2: Bytes and packet ends received during a frame do not change cpu_count_o, cpu_empty_o or cpu_data_o before the next start-of-frame strobe.
- R3: In the cycle after a start-of-frame strobe, cpu_count_o equals the length of the last good packet of the closing frame, and cpu_data_o shows its first byte.
- R4: sof_irq_o is 1 for exactly the one cycle that follows each start-of-frame strobe.
- R5: While cpu_sel_o is 1, each cycle with cpu_rd_i high and the bank not empty advances the read position by one. cpu_data_o presents the bytes in arrival order.
- R6: When the foreground bank is empty (all counted bytes read, or count 0), cpu_data_o is 0 and reads do not move the read position. A read while cpu_sel_o is 0 is ignored.
- R7: Bytes beyond PKT_LEN in one packet are dropped and set overrun_o, which stays 1. The count is then capped at PKT_LEN.
- R8: A packet closed with rx_good_i = 0 leaves the committed count at 0, so after the swap the foreground reads as empty.
- R9: cpu_release_i clears cpu_sel_o, discards the foreground bank (count 0, empty 1) and clears overrun_o. cpu_sel_set_i sets cpu_sel_o from the next cycle on.
- R10: At each swap the new background bank starts with a count of 0. A frame with no packet yields an empty foreground after the following swap.
- R11: A bus byte or end strobe in the same cycle as a start-of-frame strobe is dropped.
- R12: If a frame holds several good packets, only the last one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe, swaps bank roles |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_end_i | input | 1 | End-of-packet strobe |
| rx_good_i | input | 1 | With rx_end_i: 1 packet good, 0 packet bad |
| cpu_sel_set_i | input | 1 | Set the foreground select bit |
| cpu_release_i | input | 1 | Clear select bit and release foreground |
| cpu_rd_i | input | 1 | Read strobe, steps to the next byte |
| cpu_data_o | output | 8 | Current foreground byte, 0 when empty |
| cpu_empty_o | output | 1 | Foreground holds no unread byte |
| cpu_count_o | output | $clog2(PKT_LEN+1) | Bytes received into the foreground bank |
| cpu_sel_o | output | 1 | Select bit state |
| overrun_o | output | 1 | Sticky overrun flag |
| sof_irq_o | output | 1 | Start-of-frame interrupt pulse |

## Verification
Bus strobes update the background bank at the next rising edge but stay invisible at the processor ports until a swap. Count, empty flag, data and the interrupt all change at the edge that samples sof_i, so they are due one cycle after the strobe, and the interrupt has dropped one cycle later. A read or a release takes effect at the edge that samples it, so the next byte or the cleared state is checked one cycle later. The bench drives every input just after a falling edge and samples just after the following falling edge, so each result is read exactly one rising edge after its cause.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        EV_IDLE     = 2'd0,
        EV_BYTE     = 2'd1,
        EV_END_GOOD = 2'd2,
        EV_END_BAD  = 2'd3
    } bus_ev_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              good;
    } bus_evt_t;

    typedef struct packed {
        logic sel_set;
        logic release_fg;
        logic rd;
    } cpu_cmd_t;

    // An end marker outranks a data strobe arriving in the same cycle.
    function automatic bus_ev_e classify(input bus_evt_t e);
        if (e.last)
            return e.good ? EV_END_GOOD : EV_END_BAD;
        else if (e.valid)
            return EV_BYTE;
        return EV_IDLE;
    endfunction

endpackage

// File: rtl/iso_rx_bank.sv
module iso_rx_bank
    import iso_rx_pkg::*;
#(
    parameter int PKT_LEN = 32,
    localparam int AW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [BYTE_W-1:0] mem [PKT_LEN];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                mem[wr_addr] <= wr_data;
        end

        assign bank_q[b] = mem[rd_addr];
    end

    assign rd_data = rd_bank ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/iso_rx_wr.sv
module iso_rx_wr
    import iso_rx_pkg::*;
#(
    parameter int PKT_LEN = 32,
    localparam int AW    = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1,
    localparam int CNT_W = $clog2(PKT_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  bus_evt_t          evt,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  bg_cnt,
    output logic              drop
);

    logic [CNT_W-1:0] wr_ptr_q;
    logic [CNT_W-1:0] bg_cnt_q;
    bus_ev_e          kind;
    logic             room;

    assign kind  = classify(evt);
    assign room  = (wr_ptr_q < CNT_W'(PKT_LEN));
    assign we    = !sof && (kind == EV_BYTE) && room;
    assign drop  = !sof && (kind == EV_BYTE) && !room;
    assign waddr = wr_ptr_q[AW-1:0];
    assign wdata = evt.data;
    assign bg_cnt = bg_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            bg_cnt_q <= '0;
        end else if (sof) begin
            // Fresh background bank; any strobe in this cycle is lost.
            wr_ptr_q <= '0;
            bg_cnt_q <= '0;
        end else begin
            unique case (kind)
                EV_BYTE: begin
                    if (room)
                        wr_ptr_q <= wr_ptr_q + 1'b1;
                end
                EV_END_GOOD: begin
                    bg_cnt_q <= wr_ptr_q;
                    wr_ptr_q <= '0;
                end
                EV_END_BAD: begin
                    bg_cnt_q <= '0;
                    wr_ptr_q <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/iso_rx_rd.sv
module iso_rx_rd
    import iso_rx_pkg::*;
#(
    parameter int PKT_LEN = 32,
    localparam int AW    = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1,
    localparam int CNT_W = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic [CNT_W-1:0] bg_cnt,
    input  cpu_cmd_t         cmd,
    output logic [AW-1:0]    rd_addr,
    output logic [CNT_W-1:0] fg_cnt,
    output logic             empty,
    output logic             sel
);

    logic [CNT_W-1:0] fg_cnt_q;
    logic [CNT_W-1:0] rd_ptr_q;
    logic             sel_q;

    assign empty   = (rd_ptr_q == fg_cnt_q);
    assign rd_addr = rd_ptr_q[AW-1:0];
    assign fg_cnt  = fg_cnt_q;
    assign sel     = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (cmd.release_fg) begin
            sel_q <= 1'b0;
        end else if (cmd.sel_set) begin
            sel_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fg_cnt_q <= '0;
            rd_ptr_q <= '0;
        end else if (sof) begin
            fg_cnt_q <= bg_cnt;
            rd_ptr_q <= '0;
        end else if (cmd.release_fg) begin
            fg_cnt_q <= '0;
            rd_ptr_q <= '0;
        end else if (cmd.rd && sel_q && !empty) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/iso_pingpong_rx.sv
module iso_pingpong_rx
    import iso_rx_pkg::*;
#(
    parameter int PKT_LEN = 32,
    localparam int CNT_W = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             rx_end_i,
    input  logic             rx_good_i,
    input  logic             cpu_sel_set_i,
    input  logic             cpu_release_i,
    input  logic             cpu_rd_i,
    output logic [7:0]       cpu_data_o,
    output logic             cpu_empty_o,
    output logic [CNT_W-1:0] cpu_count_o,
    output logic             cpu_sel_o,
    output logic             overrun_o,
    output logic             sof_irq_o
);

    localparam int AW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

    bus_evt_t          evt;
    cpu_cmd_t          cmd;
    logic              bg_bank_q;
    logic              irq_q;
    logic              ovr_q;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [BYTE_W-1:0] wdata;
    logic [CNT_W-1:0]  bg_cnt;
    logic              drop;
    logic [AW-1:0]     raddr;
    logic [BYTE_W-1:0] rdata;
    logic              empty;

    assign evt = '{valid: rx_valid_i, data: rx_byte_i, last: rx_end_i, good: rx_good_i};
    assign cmd = '{sel_set: cpu_sel_set_i, release_fg: cpu_release_i, rd: cpu_rd_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            bg_bank_q <= 1'b0;
            irq_q     <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            irq_q <= sof_i;
            if (sof_i)
                bg_bank_q <= ~bg_bank_q;
            if (drop)
                ovr_q <= 1'b1;
            else if (cpu_release_i)
                ovr_q <= 1'b0;
        end
    end

    iso_rx_wr #(.PKT_LEN(PKT_LEN)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .sof    (sof_i),
        .evt    (evt),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .bg_cnt (bg_cnt),
        .drop   (drop)
    );

    iso_rx_rd #(.PKT_LEN(PKT_LEN)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .sof     (sof_i),
        .bg_cnt  (bg_cnt),
        .cmd     (cmd),
        .rd_addr (raddr),
        .fg_cnt  (cpu_count_o),
        .empty   (empty),
        .sel     (cpu_sel_o)
    );

    iso_rx_bank #(.PKT_LEN(PKT_LEN)) u_bank (
        .clk     (clk),
        .wr_en   (we),
        .wr_bank (bg_bank_q),
        .wr_addr (waddr),
        .wr_data (wdata),
        .rd_bank (~bg_bank_q),
        .rd_addr (raddr),
        .rd_data (rdata)
    );

    assign cpu_empty_o = empty;
    assign cpu_data_o  = empty ? '0 : rdata;
    assign overrun_o   = ovr_q;
    assign sof_irq_o   = irq_q;

endmodule

// File: rtl/iso_rx_chk.sv
module iso_rx_chk #(
    parameter int PKT_LEN = 32,
    localparam int CNT_W = $clog2(PKT_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             sof_i,
    input logic             cpu_release_i,
    input logic [7:0]       cpu_data_o,
    input logic             cpu_empty_o,
    input logic [CNT_W-1:0] cpu_count_o,
    input logic             cpu_sel_o,
    input logic             overrun_o,
    input logic             sof_irq_o
);

    p_irq_follows_sof_r4: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> sof_irq_o);

    p_irq_needs_sof_r4: assert property (@(posedge clk) disable iff (rst)
        !sof_i |=> !sof_irq_o);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!sof_i && !cpu_release_i) |=> $stable(cpu_count_o));

    p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_empty_o |-> (cpu_data_o == 8'd0));

    p_count_cap_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_count_o <= CNT_W'(PKT_LEN));

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !cpu_release_i) |=> overrun_o);

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_release_i && !sof_i) |=> (!cpu_sel_o && cpu_empty_o && cpu_count_o == '0));

endmodule

bind iso_pingpong_rx iso_rx_chk #(.PKT_LEN(PKT_LEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sof_i         (sof_i),
    .cpu_release_i (cpu_release_i),
    .cpu_data_o    (cpu_data_o),
    .cpu_empty_o   (cpu_empty_o),
    .cpu_count_o   (cpu_count_o),
    .cpu_sel_o     (cpu_sel_o),
    .overrun_o     (overrun_o),
    .sof_irq_o     (sof_irq_o)
);

// File: tb/sim_iso_pingpong_rx.sv
module sim_iso_pingpong_rx;

    localparam int PL = 32;
    localparam int CW = $clog2(PL + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          sof_i = 0, rx_valid_i = 0, rx_end_i = 0, rx_good_i = 0;
    logic [7:0]    rx_byte_i = 0;
    logic          cpu_sel_set_i = 0, cpu_release_i = 0, cpu_rd_i = 0;
    logic [7:0]    cpu_data_o;
    logic          cpu_empty_o, cpu_sel_o, overrun_o, sof_irq_o;
    logic [CW-1:0] cpu_count_o;

    int errs = 0;
    int checks = 0;
    int pkt [64];

    iso_pingpong_rx #(.PKT_LEN(PL)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int pat(input int base, input int i);
        return (base + i * 37 + 5) & 255;
    endfunction

    function automatic int exp_cnt(input int n, input bit good);
        if (!good) return 0;
        return (n > PL) ? PL : n;
    endfunction

    task automatic send_pkt(input int n, input bit good, input int base);
        for (int i = 0; i < n; i++) begin
            rx_valid_i = 1; rx_byte_i = 8'(pat(base, i));
            if (i < 64) pkt[i] = pat(base, i);
            step();
        end
        rx_valid_i = 0;
        rx_end_i = 1; rx_good_i = good;
        step();
        rx_end_i = 0; rx_good_i = 0;
    endtask

    task automatic do_sof(input string req);
        sof_i = 1;
        step();
        sof_i = 0;
        chk({req, " R4 irq high"}, int'(sof_irq_o), 1);
        step();
        chk({req, " R4 irq low"}, int'(sof_irq_o), 0);
    endtask

    task automatic select_fg();
        cpu_sel_set_i = 1; step(); cpu_sel_set_i = 0;
    endtask

    task automatic release_fg();
        cpu_release_i = 1; step(); cpu_release_i = 0;
    endtask

    task automatic read_all(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(cpu_data_o), pkt[i]);
            cpu_rd_i = 1; step(); cpu_rd_i = 0;
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 empty", int'(cpu_empty_o), 1);
        chk("R1 count", int'(cpu_count_o), 0);
        chk("R1 sel", int'(cpu_sel_o), 0);
        chk("R1 overrun", int'(overrun_o), 0);
        chk("R1 irq", int'(sof_irq_o), 0);
        chk("R1 data", int'(cpu_data_o), 0);

        // R2/R3/R5/R6/R9 basic frame
        send_pkt(5, 1, 10);
        chk("R2 count hidden", int'(cpu_count_o), 0);
        chk("R2 empty hidden", int'(cpu_empty_o), 1);
        do_sof("R3");
        chk("R3 count", int'(cpu_count_o), 5);
        chk("R3 first byte", int'(cpu_data_o), pkt[0]);
        cpu_rd_i = 1; step(); cpu_rd_i = 0;
        chk("R6 read unselected ignored", int'(cpu_data_o), pkt[0]);
        select_fg();
        chk("R9 sel set", int'(cpu_sel_o), 1);
        read_all(5, "R5 byte order");
        chk("R6 empty after drain", int'(cpu_empty_o), 1);
        cpu_rd_i = 1; step(); cpu_rd_i = 0;
        chk("R6 empty read zero", int'(cpu_data_o), 0);
        chk("R6 count kept", int'(cpu_count_o), 5);
        release_fg();
        chk("R9 sel cleared", int'(cpu_sel_o), 0);
        chk("R9 count cleared", int'(cpu_count_o), 0);
        chk("R9 empty", int'(cpu_empty_o), 1);

        // R8 bad packet
        send_pkt(6, 0, 77);
        do_sof("R8");
        chk("R8 bad count", int'(cpu_count_o), 0);
        chk("R8 bad empty", int'(cpu_empty_o), 1);

        // R7 overrun
        send_pkt(PL + 3, 1, 3);
        chk("R7 overrun set", int'(overrun_o), 1);
        step();
        chk("R7 overrun sticky", int'(overrun_o), 1);
        do_sof("R7");
        chk("R7 count capped", int'(cpu_count_o), PL);
        select_fg();
        read_all(PL, "R7 kept bytes");
        chk("R7 drained", int'(cpu_empty_o), 1);
        release_fg();
        chk("R9 overrun cleared", int'(overrun_o), 0);

        // R10 empty frame after swap
        send_pkt(4, 1, 200);
        do_sof("R10");
        chk("R10 count", int'(cpu_count_o), 4);
        do_sof("R10");
        chk("R10 new background empty", int'(cpu_count_o), 0);
        chk("R10 empty flag", int'(cpu_empty_o), 1);

        // R11 strobe coincident with SOF
        send_pkt(3, 1, 50);
        sof_i = 1; rx_valid_i = 1; rx_byte_i = 8'hAA;
        step();
        sof_i = 0; rx_valid_i = 0;
        chk("R11 swapped count", int'(cpu_count_o), 3);
        rx_end_i = 1; rx_good_i = 1; step(); rx_end_i = 0; rx_good_i = 0;
        do_sof("R11");
        chk("R11 byte dropped", int'(cpu_count_o), 0);

        // R12 last good packet wins
        send_pkt(4, 1, 90);
        send_pkt(2, 1, 140);
        do_sof("R12");
        chk("R12 count", int'(cpu_count_o), 2);
        select_fg();
        read_all(2, "R12 bytes");
        release_fg();

        // Random frames
        for (int f = 0; f < 40; f++) begin
            int n, base;
            bit good;
            n = $urandom_range(0, PL + 4);
            good = ($urandom_range(0, 3) != 0);
            base = $urandom_range(0, 255);
            send_pkt(n, good, base);
            chk("R2 random hidden", int'(cpu_count_o), 0);
            chk("R7 random overrun", int'(overrun_o), (n > PL) ? 1 : 0);
            do_sof("R3 random");
            chk("R3 random count", int'(cpu_count_o), exp_cnt(n, good));
            select_fg();
            read_all(exp_cnt(n, good), "R5 random data");
            chk("R6 random empty", int'(cpu_empty_o), 1);
            release_fg();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule